// File: doc/BRIEF.md
# Filtered Event Counter Bank

This block holds four event counters of 32 bits, each with a control register that chooses which event it counts and under which conditions. Software reaches all eight registers through a 3-bit register select, a write strobe with write data, and a read strobe that returns the selected register combinationally. Control registers sit at even select values and counts at odd ones: select 2n is the control of counter n, and select 2n+1 is its count.

Each clock cycle the bank receives two vectors of event pulses. Even counters (0 and 2) take one vector and odd counters (1 and 3) take the other, so one event code names complementary events on the two pairs. Along with the pulses come the context tag and group tag of the issuing thread, the user, supervisor and kernel mode bits, and the exception-level and error-level bits. A counter advances by one when its chosen event fires, a privilege enable matches, and its tag filter passes. Some event codes are machine-wide. The parameters list them per pair, and these codes pass the tag filter whatever it is set to. One interrupt line goes high while any counter has its interrupt enable set and the top bit of its count set.

The bank is a set of registers with no sequencing. Each counter slot is a control register plus a count register with one update rule each cycle: reset, then a write, then an increment, then hold.

Top module: `evb_counter_bank`

## Requirements
- R1: A read with `rd_en` high returns the selected register, and `rd_data` is zero while `rd_en` is low. A control read shows bit 31 as 1 for counters 0 to 2 and 0 for counter 3. Bits 30 and 15:12 read as zero. The writable fields are context tag 29:22, filter mode 21:20, group tag 19:16, event code 11:5, interrupt enable 4, user 3, supervisor 2, kernel 1 and exception 0.
- R2: A counter increments by exactly one in a cycle where its qualifying conditions hold. Even counters index `evt_even` by the event code and odd counters index `evt_odd`.
- R3: The user, supervisor and kernel enables each allow counting only while the matching mode input is 1.
- R4: The exception enable allows counting only while `exc_lvl` is 1 and `err_lvl` is 0.
- R5: Filter mode 00 passes every tag. Mode 01 passes only when `grp_tag` equals the group field. Mode 10 passes only when `ctx_tag` equals the context field. Mode 11 passes nothing.
- R6: Codes marked machine-wide in the parameter mask for the counter's pair ignore the filter mode and both tag fields.
- R7: Event codes 56 to 127 never increment a counter.
- R8: When a count write and a qualifying event fall in the same cycle, the written value is stored without the increment.
- R9: A count at 0xFFFFFFFF wraps to 0 on the next qualifying event.
- R10: `irq` is high exactly while some counter has interrupt enable 1 and count bit 31 set. Writing a count with bit 31 clear removes that counter's contribution.
- R11: Reset clears every count and every writable control field, so the interrupt enable is 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 3 | Register select (even: control, odd: count) |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Selected register, zero when not reading |
| evt_even | input | 56 | Event pulses by code, for counters 0 and 2 |
| evt_odd | input | 56 | Event pulses by code, for counters 1 and 3 |
| ctx_tag | input | 8 | Context of the issuing thread |
| grp_tag | input | 4 | Group of the issuing thread |
| priv_user | input | 1 | User mode active |
| priv_super | input | 1 | Supervisor mode active |
| priv_kern | input | 1 | Kernel mode active |
| exc_lvl | input | 1 | Exception level bit |
| err_lvl | input | 1 | Error level bit |
| irq | output | 1 | Half-full interrupt |

## Verification
A wrong count or control state does not show at the ports on its own. It appears on the first read of that register, and `irq` shows it only once bit 31 is involved. For that reason the bench reads a register on almost every cycle and compares `irq` every cycle against a behavioural model. A stray or missing increment is then reported within a few cycles of occurring. A filter or pair-routing fault shows up as a count that drifts from the model under dense random event traffic.

// File: rtl/evbank_pkg.sv
package evbank_pkg;

    localparam int CNT_W  = 32;
    localparam int CTX_W  = 8;
    localparam int GRP_W  = 4;
    localparam int CODE_W = 7;

    typedef enum logic [1:0] {
        FLT_ALL   = 2'b00,
        FLT_GROUP = 2'b01,
        FLT_CTX   = 2'b10,
        FLT_RSVD  = 2'b11
    } flt_mode_e;

    typedef struct packed {
        logic [CTX_W-1:0]  ctx;
        flt_mode_e         fmode;
        logic [GRP_W-1:0]  grp;
        logic [CODE_W-1:0] code;
        logic              irq_en;
        logic              en_usr;
        logic              en_sup;
        logic              en_krn;
        logic              en_exc;
    } slot_cfg_t;

    function automatic slot_cfg_t cfg_from_word(input logic [CNT_W-1:0] w);
        slot_cfg_t c;
        c.ctx    = w[29:22];
        c.fmode  = flt_mode_e'(w[21:20]);
        c.grp    = w[19:16];
        c.code   = w[11:5];
        c.irq_en = w[4];
        c.en_usr = w[3];
        c.en_sup = w[2];
        c.en_krn = w[1];
        c.en_exc = w[0];
        return c;
    endfunction

    function automatic logic [CNT_W-1:0] cfg_to_word(input slot_cfg_t c, input logic more);
        return {more, 1'b0, c.ctx, c.fmode, c.grp, 4'b0000, c.code,
                c.irq_en, c.en_usr, c.en_sup, c.en_krn, c.en_exc};
    endfunction

    localparam logic [55:0] WIDE_BOTH = (56'd1 << 0)  | (56'd1 << 12) | (56'd1 << 13) |
                                        (56'd1 << 21) | (56'd1 << 22) | (56'd1 << 25) |
                                        (56'd1 << 38) | (56'd1 << 39) | (56'h3F << 50);
    localparam logic [55:0] WIDE_EVEN_DEF = WIDE_BOTH | (56'd1 << 18) | (56'd1 << 44);
    localparam logic [55:0] WIDE_ODD_DEF  = WIDE_BOTH | (56'd1 << 46) | (56'd1 << 48);

endpackage

// File: rtl/evb_filter.sv
module evb_filter
    import evbank_pkg::*;
#(
    parameter int NUM_CODES = 56
) (
    input  slot_cfg_t              cfg,
    input  logic [NUM_CODES-1:0]   evt_vec,
    input  logic [NUM_CODES-1:0]   wide_mask,
    input  logic [CTX_W-1:0]       ctx_tag,
    input  logic [GRP_W-1:0]       grp_tag,
    input  logic                   priv_user,
    input  logic                   priv_super,
    input  logic                   priv_kern,
    input  logic                   exc_lvl,
    input  logic                   err_lvl,
    output logic                   hit
);

    localparam int IDX_W = $clog2(NUM_CODES);

    logic code_ok;
    logic fired;
    logic wide;
    logic mode_ok;
    logic tag_ok;

    always_comb begin
        code_ok = (32'(cfg.code) < NUM_CODES);
        fired   = 1'b0;
        wide    = 1'b0;
        if (code_ok) begin
            fired = evt_vec[cfg.code[IDX_W-1:0]];
            wide  = wide_mask[cfg.code[IDX_W-1:0]];
        end

        mode_ok = (cfg.en_usr & priv_user) |
                  (cfg.en_sup & priv_super) |
                  (cfg.en_krn & priv_kern) |
                  (cfg.en_exc & exc_lvl & ~err_lvl);

        unique case (cfg.fmode)
            FLT_ALL:   tag_ok = 1'b1;
            FLT_GROUP: tag_ok = (grp_tag == cfg.grp);
            FLT_CTX:   tag_ok = (ctx_tag == cfg.ctx);
            FLT_RSVD:  tag_ok = 1'b0;
            default:   tag_ok = 1'b0;
        endcase

        hit = fired & mode_ok & (wide | tag_ok);
    end

endmodule

// File: rtl/evb_slot.sv
module evb_slot
    import evbank_pkg::*;
#(
    parameter int             NUM_CODES = 56,
    parameter bit             IS_ODD    = 1'b0,
    parameter logic [NUM_CODES-1:0] WIDE_EVEN = WIDE_EVEN_DEF[NUM_CODES-1:0],
    parameter logic [NUM_CODES-1:0] WIDE_ODD  = WIDE_ODD_DEF[NUM_CODES-1:0]
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic                 cnt_we,
    input  logic [CNT_W-1:0]     wr_data,
    input  logic [NUM_CODES-1:0] evt_even,
    input  logic [NUM_CODES-1:0] evt_odd,
    input  logic [CTX_W-1:0]     ctx_tag,
    input  logic [GRP_W-1:0]     grp_tag,
    input  logic                 priv_user,
    input  logic                 priv_super,
    input  logic                 priv_kern,
    input  logic                 exc_lvl,
    input  logic                 err_lvl,
    output slot_cfg_t            cfg_q,
    output logic [CNT_W-1:0]     cnt_q,
    output logic                 irq_o
);

    logic [NUM_CODES-1:0] pair_vec;
    logic [NUM_CODES-1:0] pair_mask;
    logic                 hit;

    generate
        if (IS_ODD) begin : g_odd
            assign pair_vec  = evt_odd;
            assign pair_mask = WIDE_ODD;
        end else begin : g_even
            assign pair_vec  = evt_even;
            assign pair_mask = WIDE_EVEN;
        end
    endgenerate

    evb_filter #(.NUM_CODES(NUM_CODES)) u_flt (
        .cfg       (cfg_q),
        .evt_vec   (pair_vec),
        .wide_mask (pair_mask),
        .ctx_tag   (ctx_tag),
        .grp_tag   (grp_tag),
        .priv_user (priv_user),
        .priv_super(priv_super),
        .priv_kern (priv_kern),
        .exc_lvl   (exc_lvl),
        .err_lvl   (err_lvl),
        .hit       (hit)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            cnt_q <= '0;
        end else begin
            if (cfg_we) begin
                cfg_q <= cfg_from_word(wr_data);
            end
            if (cnt_we) begin
                cnt_q <= wr_data;
            end else if (hit) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign irq_o = cfg_q.irq_en & cnt_q[CNT_W-1];

    // R2
    step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_we && hit) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R8
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> (cnt_q == $past(wr_data)));

    // R7
    reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_we && (32'(cfg_q.code) >= NUM_CODES)) |=> $stable(cnt_q));

    // R9
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_we && hit && (&cnt_q)) |=> (cnt_q == '0));

    // R10
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_we && !wr_data[CNT_W-1]) |=> !irq_o);

endmodule

// File: rtl/evb_counter_bank.sv
module evb_counter_bank
    import evbank_pkg::*;
#(
    parameter int NUM_CTR   = 4,
    parameter int NUM_CODES = 56,
    parameter logic [NUM_CODES-1:0] WIDE_EVEN = WIDE_EVEN_DEF[NUM_CODES-1:0],
    parameter logic [NUM_CODES-1:0] WIDE_ODD  = WIDE_ODD_DEF[NUM_CODES-1:0],
    localparam int SLOT_W = $clog2(NUM_CTR),
    localparam int SEL_W  = SLOT_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SEL_W-1:0]     sel,
    input  logic                 wr_en,
    input  logic [CNT_W-1:0]     wr_data,
    input  logic                 rd_en,
    output logic [CNT_W-1:0]     rd_data,
    input  logic [NUM_CODES-1:0] evt_even,
    input  logic [NUM_CODES-1:0] evt_odd,
    input  logic [CTX_W-1:0]     ctx_tag,
    input  logic [GRP_W-1:0]     grp_tag,
    input  logic                 priv_user,
    input  logic                 priv_super,
    input  logic                 priv_kern,
    input  logic                 exc_lvl,
    input  logic                 err_lvl,
    output logic                 irq
);

    slot_cfg_t        cfg_q   [NUM_CTR];
    logic [CNT_W-1:0] cnt_q   [NUM_CTR];
    logic [CNT_W-1:0] cfg_img [NUM_CTR];
    logic [NUM_CTR-1:0] irq_vec;
    logic [SLOT_W-1:0]  slot_sel;

    assign slot_sel = sel[SEL_W-1:1];

    generate
        for (genvar g = 0; g < NUM_CTR; g++) begin : g_slot
            logic cfg_we;
            logic cnt_we;
            assign cfg_we = wr_en && (slot_sel == SLOT_W'(g)) && !sel[0];
            assign cnt_we = wr_en && (slot_sel == SLOT_W'(g)) &&  sel[0];

            evb_slot #(
                .NUM_CODES(NUM_CODES),
                .IS_ODD   ((g % 2) == 1),
                .WIDE_EVEN(WIDE_EVEN),
                .WIDE_ODD (WIDE_ODD)
            ) u_slot (
                .clk       (clk),
                .rst_n     (rst_n),
                .cfg_we    (cfg_we),
                .cnt_we    (cnt_we),
                .wr_data   (wr_data),
                .evt_even  (evt_even),
                .evt_odd   (evt_odd),
                .ctx_tag   (ctx_tag),
                .grp_tag   (grp_tag),
                .priv_user (priv_user),
                .priv_super(priv_super),
                .priv_kern (priv_kern),
                .exc_lvl   (exc_lvl),
                .err_lvl   (err_lvl),
                .cfg_q     (cfg_q[g]),
                .cnt_q     (cnt_q[g]),
                .irq_o     (irq_vec[g])
            );

            assign cfg_img[g] = cfg_to_word(cfg_q[g], (g < NUM_CTR - 1));
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            rd_data = sel[0] ? cnt_q[slot_sel] : cfg_img[slot_sel];
        end
    end

    assign irq = |irq_vec;

endmodule

// File: tb/sim_evb_counter_bank.sv
module sim_evb_counter_bank;

    localparam int CLK_PERIOD = 10;
    localparam logic [55:0] BOTH = (56'd1 << 0) | (56'd1 << 12) | (56'd1 << 13) |
                                   (56'd1 << 21) | (56'd1 << 22) | (56'd1 << 25) |
                                   (56'd1 << 38) | (56'd1 << 39) | (56'h3F << 50);
    localparam logic [55:0] TB_WIDE_E = BOTH | (56'd1 << 18) | (56'd1 << 44);
    localparam logic [55:0] TB_WIDE_O = BOTH | (56'd1 << 46) | (56'd1 << 48);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  s_sel = '0;
    logic        s_we = 1'b0;
    logic [31:0] s_wd = '0;
    logic        s_re = 1'b1;
    logic [31:0] rd_data;
    logic [55:0] ee = '0, eo = '0;
    logic [7:0]  ctx = '0;
    logic [3:0]  grp = '0;
    logic        mu = 0, ms = 0, mk = 0, exl = 0, erl = 0;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    logic [2:0] rsel = '0;
    bit done = 0;

    logic [31:0] m_ctl [4];
    logic [31:0] m_cnt [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    evb_counter_bank #(
        .NUM_CTR(4), .NUM_CODES(56), .WIDE_EVEN(TB_WIDE_E), .WIDE_ODD(TB_WIDE_O)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .sel(s_sel), .wr_en(s_we), .wr_data(s_wd),
        .rd_en(s_re), .rd_data(rd_data), .evt_even(ee), .evt_odd(eo),
        .ctx_tag(ctx), .grp_tag(grp), .priv_user(mu), .priv_super(ms),
        .priv_kern(mk), .exc_lvl(exl), .err_lvl(erl), .irq(irq)
    );

    function automatic logic [31:0] mk_ctl(input int c, input int fm, input int g, input int code,
                                           input bit ie, input bit u, input bit s, input bit k, input bit x);
        logic [31:0] w;
        w = '0;
        w[29:22] = c[7:0];
        w[21:20] = fm[1:0];
        w[19:16] = g[3:0];
        w[11:5]  = code[6:0];
        w[4] = ie; w[3] = u; w[2] = s; w[1] = k; w[0] = x;
        return w;
    endfunction

    function automatic bit qual(input int n);
        int code;
        bit ev, glob, mode_ok, filt;
        logic [31:0] c;
        c = m_ctl[n];
        code = int'(c[11:5]);
        if (code >= 56) return 0;
        ev   = (n % 2 == 1) ? eo[code] : ee[code];
        glob = (n % 2 == 1) ? TB_WIDE_O[code] : TB_WIDE_E[code];
        mode_ok = (c[3] && mu) || (c[2] && ms) || (c[1] && mk) || (c[0] && exl && !erl);
        case (c[21:20])
            2'b00: filt = 1;
            2'b01: filt = (grp == c[19:16]);
            2'b10: filt = (ctx == c[29:22]);
            default: filt = 0;
        endcase
        return ev && mode_ok && (glob || filt);
    endfunction

    function automatic logic [31:0] exp_rd();
        int n;
        if (!s_re) return '0;
        n = int'(s_sel[2:1]);
        if (s_sel[0]) return m_cnt[n];
        return m_ctl[n] | ((n < 3) ? 32'h8000_0000 : 32'h0);
    endfunction

    function automatic logic exp_irq();
        logic r;
        r = 0;
        for (int n = 0; n < 4; n++) r |= m_ctl[n][4] & m_cnt[n][31];
        return r;
    endfunction

    task automatic compare(input string tag);
        logic [31:0] er;
        logic ei;
        er = exp_rd();
        ei = exp_irq();
        checks++;
        if (rd_data !== er) begin
            fails++;
            $display("FAIL %s rd sel=%0d actual=%h expected=%h", tag, s_sel, rd_data, er);
        end
        checks++;
        if (irq !== ei) begin
            fails++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq, ei);
        end
    endtask

    task automatic model_edge();
        bit h [4];
        int w;
        for (int n = 0; n < 4; n++) h[n] = qual(n);
        w = int'(s_sel[2:1]);
        for (int n = 0; n < 4; n++) begin
            if (s_we && w == n && s_sel[0]) m_cnt[n] = s_wd;
            else if (h[n]) m_cnt[n] = m_cnt[n] + 32'd1;
            if (s_we && w == n && !s_sel[0]) m_ctl[n] = s_wd & 32'h3FFF_0FFF;
        end
    endtask

    // One cycle: inputs are already set at the falling edge.
    task automatic tick(input string tag);
        if (!s_we) begin
            s_sel = rsel;
            rsel  = rsel + 3'd1;
        end
        #1;
        compare(tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        s_we = 0;
    endtask

    task automatic wr(input int sl, input logic [31:0] d, input string tag);
        s_we = 1; s_sel = sl[2:0]; s_wd = d;
        tick(tag);
    endtask

    task automatic evts(input int cycles, input string tag);
        for (int i = 0; i < cycles; i++) tick(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int n = 0; n < 4; n++) begin m_ctl[n] = '0; m_cnt[n] = '0; end
        repeat (3) @(negedge clk);
        // R11: register contents and irq under reset
        for (int n = 0; n < 8; n++) begin
            s_sel = n[2:0]; #1; compare("R11"); @(negedge clk);
        end
        rst_n = 1;
        for (int n = 0; n < 8; n++) tick("R11");

        // R1: layout of control reads, reserved bits and no-read output
        for (int n = 0; n < 4; n++) wr(2*n, 32'hFFFF_FFFF, "R1");
        ee = '1; eo = '1; mu = 1;
        evts(8, "R1");
        s_re = 0; evts(2, "R1"); s_re = 1;
        ee = '0; eo = '0;
        for (int n = 0; n < 4; n++) begin wr(2*n, '0, "R1"); wr(2*n+1, '0, "R1"); end

        // R2: pair routing, code 1 on both pairs
        for (int n = 0; n < 4; n++) wr(2*n, mk_ctl(0, 0, 0, 1, 0, 1, 0, 0, 0), "R2");
        ee = 56'd1 << 1; evts(5, "R2");
        ee = '0; eo = 56'd1 << 1; evts(5, "R2");
        eo = '0;

        // R3: privilege enables
        wr(0, mk_ctl(0, 0, 0, 2, 0, 0, 0, 1, 0), "R3");
        wr(2, mk_ctl(0, 0, 0, 2, 0, 0, 1, 0, 0), "R3");
        ee = 56'd1 << 2;
        mu = 1; ms = 0; mk = 0; evts(4, "R3");
        mu = 0; ms = 1; evts(4, "R3");
        ms = 0; mk = 1; evts(4, "R3");
        mk = 0; evts(2, "R3");

        // R4: exception enable
        wr(0, mk_ctl(0, 0, 0, 2, 0, 0, 0, 0, 1), "R4");
        exl = 1; erl = 0; evts(4, "R4");
        erl = 1; evts(4, "R4");
        exl = 0; erl = 0; evts(4, "R4");

        // R5: filter modes
        mu = 1; ee = 56'd1 << 3; eo = 56'd1 << 3;
        wr(0, mk_ctl(0, 1, 3, 3, 0, 1, 0, 0, 0), "R5");
        wr(2, mk_ctl(5, 2, 0, 3, 0, 1, 0, 0, 0), "R5");
        wr(1, mk_ctl(5, 3, 3, 3, 0, 1, 0, 0, 0), "R5");
        grp = 3; ctx = 5; evts(4, "R5");
        grp = 2; evts(4, "R5");
        ctx = 6; grp = 3; evts(4, "R5");

        // R6: machine-wide code 0 ignores mismatched tags
        wr(0, mk_ctl(9, 2, 0, 0, 0, 1, 0, 0, 0), "R6");
        wr(1, mk_ctl(9, 3, 7, 0, 0, 1, 0, 0, 0), "R6");
        ctx = 0; grp = 0; ee = 56'd1; eo = 56'd1; evts(6, "R6");

        // R7: reserved codes
        ee = '1; eo = '1;
        wr(0, mk_ctl(0, 0, 0, 56, 0, 1, 0, 0, 0), "R7");
        wr(2, mk_ctl(0, 0, 0, 100, 0, 1, 0, 0, 0), "R7");
        wr(4, mk_ctl(0, 0, 0, 127, 0, 1, 0, 0, 0), "R7");
        wr(6, mk_ctl(0, 0, 0, 63, 0, 1, 0, 0, 0), "R7");
        evts(8, "R7");

        // R8: write beats event
        for (int n = 0; n < 4; n++) wr(2*n, mk_ctl(0, 0, 0, 1, 0, 1, 0, 0, 0), "R8");
        wr(1, 32'h0000_1234, "R8");
        wr(3, 32'h0000_0000, "R8");
        evts(4, "R8");

        // R9: wrap
        wr(5, 32'hFFFF_FFFF, "R9");
        evts(4, "R9");

        // R10: half-full interrupt and its clearing
        ee = '0; eo = '0;
        wr(6, mk_ctl(0, 0, 0, 1, 1, 1, 0, 0, 0), "R10");
        wr(7, 32'h7FFF_FFFE, "R10");
        eo = 56'd1 << 1; evts(4, "R10");
        eo = '0; evts(2, "R10");
        wr(7, 32'h0, "R10");
        evts(2, "R10");
        wr(7, 32'h8000_0000, "R10");
        wr(6, mk_ctl(0, 0, 0, 1, 0, 1, 0, 0, 0), "R10");
        evts(2, "R10");

        // Mixed random traffic across all rules
        for (int i = 0; i < 4000; i++) begin
            int r, codes [10];
            codes = '{0, 1, 2, 12, 18, 37, 46, 48, 60, 127};
            ee = {$urandom, $urandom}; eo = {$urandom, $urandom};
            ctx = 8'($urandom_range(0, 3)); grp = 4'($urandom_range(0, 3));
            r = $urandom_range(0, 3);
            mu = (r == 0); ms = (r == 1); mk = (r == 2);
            exl = 1'($urandom); erl = 1'($urandom);
            s_re = ($urandom_range(0, 9) != 0);
            if ($urandom_range(0, 7) == 0) begin
                int sl;
                logic [31:0] d;
                sl = $urandom_range(0, 7);
                if (sl % 2 == 0) begin
                    d = mk_ctl($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
                               codes[$urandom_range(0, 9)], 1'($urandom), 1'($urandom),
                               1'($urandom), 1'($urandom), 1'($urandom));
                    d[31:30] = 2'($urandom); d[15:12] = 4'($urandom);
                end else begin
                    case ($urandom_range(0, 3))
                        0: d = 32'h0;
                        1: d = 32'h7FFF_FFF8;
                        2: d = 32'hFFFF_FFF8;
                        default: d = $urandom;
                    endcase
                end
                s_we = 1; s_sel = sl[2:0]; s_wd = d;
            end
            tick("RND");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule